// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash device. It watches write cycles on the host bus, one clock-wide strobe per cycle with an address and a data word. It recognises the two-write unlock prefix and the command byte that follows it, then sends single-cycle requests to the embedded program/erase engine. A program request carries the latched target address and data. A chip-erase request carries nothing else. A sector-erase start carries a mask of the sectors that were collected. Suspend and resume requests are also produced.

Any write that breaks a sequence sends the decoder back to read mode. While an embedded operation runs, the decoder waits for the engine's busy flag to fall and then returns to read mode by itself. Only a running sector erase can be suspended or resumed. The mode outputs show whether the decoder is in read mode, in autoselect mode, or holding a suspended erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `read_mode` is 1, `autosel_mode` and `erase_suspended` are 0, `sect_mask` is 0 and no request pulse is high.
- R2: The sequence AAH@5555H, 55H@2AAAH, A0H@5555H followed by any fourth write makes `req_prog` high for exactly the clock after the fourth write. In that clock `prog_addr` and `prog_data` hold the fourth write's address and full data word.
- R3: With `byte_mode`=1 the two unlock addresses become AAAAH and 5554H, and command bytes are written to AAAAH. In that mode the word-mode address 5555H does not unlock.
- R4: The unlock, 80H@5555H, a second unlock, then 10H@5555H make `req_chip_erase` high for one clock after the sixth write.
- R5: Ending the erase prefix with 30H at any address opens a sector window. Each 30H write inside the window sets the mask bit named by the top log2(N_SECT) address bits and restarts the window. `req_sect_start` pulses exactly WIN_CYC clocks after the last accepted 30H write, with `sect_mask` holding the collected bits.
- R6: A write with a wrong address or a wrong data byte at any step of a sequence returns to read mode. A command byte written after that, without a fresh unlock, issues nothing. A non-30H write inside the sector window aborts the erase, and no start pulse follows.
- R7: Bits 15..8 of the data word are ignored when matching unlock and command bytes.
- R8: While a sector erase runs, a B0H write pulses `req_suspend` and sets `erase_suspended`. While suspended, a 30H write pulses `req_resume` and clears it. A B0H write in read mode or during a chip erase pulses nothing.
- R9: In a program, chip-erase or sector-erase run, a fall of `eng_busy` returns the decoder to read mode one clock later. A fall while the erase is suspended leaves it suspended.
- R10: The command byte 90H after the unlock sets `autosel_mode`. The next write, for example F0H, clears it and returns to read mode.
- R11: Writes during a program or chip-erase run produce no request and do not leave the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 1 selects 8-bit bus addressing for the unlock addresses |
| wr_en | input | 1 | One-clock write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; only bits 7..0 are decoded |
| eng_busy | input | 1 | Embedded engine busy flag |
| read_mode | output | 1 | Decoder is idle in read mode |
| autosel_mode | output | 1 | Autoselect mode active |
| erase_suspended | output | 1 | Sector erase is suspended |
| req_prog | output | 1 | Program request pulse |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | DATA_W | Latched program data |
| req_chip_erase | output | 1 | Chip-erase request pulse |
| req_sect_start | output | 1 | Sector-erase start pulse |
| sect_mask | output | N_SECT | Sectors selected for erase |
| req_suspend | output | 1 | Erase-suspend request pulse |
| req_resume | output | 1 | Erase-resume request pulse |

## Verification
The bench builds the block with a 16-bit address, 8 sectors and a 6-clock sector window. The window is short enough that the bench can count the exact clock of the start pulse and confirm the clock just before it is still quiet. Eight sectors put the highest sector index (address E000H, bit 7) within reach, next to a low one, so mask accumulation is exercised at both ends of the vector. The 16-bit address also holds the byte-mode unlock address AAAAH without truncation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PROG_ARM, S_ERS0, S_ERS1, S_ERS2,
    S_SE_WIN, S_SE_RUN, S_SUSP, S_PROG_RUN, S_CHIP_RUN, S_AUTO
  } dec_state_e;

  typedef enum logic [3:0] {
    B_AA, B_55, B_A0, B_80, B_10, B_30, B_90, B_B0, B_F0, B_OTHER
  } cmd_byte_e;

  // Classify the low data byte of a bus write.
  function automatic cmd_byte_e classify(input logic [7:0] lo);
    case (lo)
      8'hAA:   return B_AA;
      8'h55:   return B_55;
      8'hA0:   return B_A0;
      8'h80:   return B_80;
      8'h10:   return B_10;
      8'h30:   return B_30;
      8'h90:   return B_90;
      8'hB0:   return B_B0;
      8'hF0:   return B_F0;
      default: return B_OTHER;
    endcase
  endfunction

  // Unlock address: first (5555H) or second (2AAAH) in word mode,
  // shifted up one bit in byte mode.
  function automatic logic [16:0] unlock_addr(input logic first, input logic byte_mode);
    logic [16:0] w;
    w = first ? 17'h05555 : 17'h02AAA;
    return byte_mode ? (w << 1) : w;
  endfunction

endpackage

// File: rtl/fcd_bus_decode.sv
module fcd_bus_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_lo,
  output logic              at_first,
  output logic              at_second,
  output cmd_byte_e         kind
);
  localparam int EXT_W = (ADDR_W > 17) ? ADDR_W : 17;

  logic [EXT_W-1:0] addr_ext;
  logic [EXT_W-1:0] first_ext;
  logic [EXT_W-1:0] second_ext;

  always_comb begin
    addr_ext   = EXT_W'(addr);
    first_ext  = EXT_W'(unlock_addr(1'b1, byte_mode));
    second_ext = EXT_W'(unlock_addr(1'b0, byte_mode));
    at_first   = (addr_ext == first_ext);
    at_second  = (addr_ext == second_ext);
    kind       = classify(data_lo);
  end
endmodule

// File: rtl/fcd_erase_window.sv
module fcd_erase_window #(
  parameter int ADDR_W  = 16,
  parameter int N_SECT  = 8,
  parameter int WIN_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_win,
  input  logic              add_en,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  output logic              expire,
  output logic [N_SECT-1:0] mask
);
  localparam int SB    = (N_SECT > 1) ? $clog2(N_SECT) : 1;
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0]  cnt;
  logic [SB-1:0]     idx;
  logic [N_SECT-1:0] bit_sel;

  assign idx     = addr[ADDR_W-1 -: SB];
  assign bit_sel = N_SECT'(1) << idx;
  assign expire  = open_win && (cnt == CNT_W'(WIN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      mask <= '0;
    end else begin
      if (add_en)
        cnt <= '0;
      else if (open_win && !expire)
        cnt <= cnt + 1'b1;
      if (clr)
        mask <= bit_sel;
      else if (add_en)
        mask <= mask | bit_sel;
    end
  end

  p_window_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    open_win |-> (cnt < CNT_W'(WIN_CYC)));
  p_add_sets_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> (mask != '0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int N_SECT  = 8,
  parameter int WIN_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_busy,
  output logic              read_mode,
  output logic              autosel_mode,
  output logic              erase_suspended,
  output logic              req_prog,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              req_chip_erase,
  output logic              req_sect_start,
  output logic [N_SECT-1:0] sect_mask,
  output logic              req_suspend,
  output logic              req_resume
);
  dec_state_e state, state_nx;
  cmd_byte_e  kind;
  logic at_first, at_second;
  logic busy_q, busy_fell;
  logic win_open, win_add, win_clr, win_expire;
  logic prog_nx, chip_nx, start_nx, susp_nx, res_nx;

  fcd_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .byte_mode (byte_mode),
    .addr      (wr_addr),
    .data_lo   (wr_data[7:0]),
    .at_first  (at_first),
    .at_second (at_second),
    .kind      (kind)
  );

  fcd_erase_window #(.ADDR_W(ADDR_W), .N_SECT(N_SECT), .WIN_CYC(WIN_CYC)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_win (win_open),
    .add_en   (win_add),
    .clr      (win_clr),
    .addr     (wr_addr),
    .expire   (win_expire),
    .mask     (sect_mask)
  );

  assign busy_fell = busy_q && !eng_busy;
  assign win_open  = (state == S_SE_WIN);

  always_comb begin
    state_nx = state;
    prog_nx  = 1'b0;
    chip_nx  = 1'b0;
    start_nx = 1'b0;
    susp_nx  = 1'b0;
    res_nx   = 1'b0;
    win_add  = 1'b0;
    win_clr  = 1'b0;
    case (state)
      S_READ:
        if (wr_en && at_first && kind == B_AA) state_nx = S_UNL1;
      S_UNL1:
        if (wr_en) state_nx = (at_second && kind == B_55) ? S_UNL2 : S_READ;
      S_UNL2:
        if (wr_en) begin
          state_nx = S_READ;
          if (at_first && kind == B_A0) state_nx = S_PROG_ARM;
          if (at_first && kind == B_80) state_nx = S_ERS0;
          if (at_first && kind == B_90) state_nx = S_AUTO;
        end
      S_PROG_ARM:
        if (wr_en) begin
          state_nx = S_PROG_RUN;
          prog_nx  = 1'b1;
        end
      S_ERS0:
        if (wr_en) state_nx = (at_first && kind == B_AA) ? S_ERS1 : S_READ;
      S_ERS1:
        if (wr_en) state_nx = (at_second && kind == B_55) ? S_ERS2 : S_READ;
      S_ERS2:
        if (wr_en) begin
          state_nx = S_READ;
          if (at_first && kind == B_10) begin
            state_nx = S_CHIP_RUN;
            chip_nx  = 1'b1;
          end else if (kind == B_30) begin
            state_nx = S_SE_WIN;
            win_add  = 1'b1;
            win_clr  = 1'b1;
          end
        end
      S_SE_WIN:
        if (wr_en) begin
          if (kind == B_30) win_add = 1'b1;
          else              state_nx = S_READ;
        end else if (win_expire) begin
          state_nx = S_SE_RUN;
          start_nx = 1'b1;
        end
      S_SE_RUN:
        if (wr_en && kind == B_B0) begin
          state_nx = S_SUSP;
          susp_nx  = 1'b1;
        end else if (busy_fell) state_nx = S_READ;
      S_SUSP:
        if (wr_en && kind == B_30) begin
          state_nx = S_SE_RUN;
          res_nx   = 1'b1;
        end
      S_PROG_RUN, S_CHIP_RUN:
        if (busy_fell) state_nx = S_READ;
      S_AUTO:
        if (wr_en) state_nx = S_READ;
      default: state_nx = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_READ;
      busy_q         <= 1'b0;
      req_prog       <= 1'b0;
      req_chip_erase <= 1'b0;
      req_sect_start <= 1'b0;
      req_suspend    <= 1'b0;
      req_resume     <= 1'b0;
      prog_addr      <= '0;
      prog_data      <= '0;
    end else begin
      state          <= state_nx;
      busy_q         <= eng_busy;
      req_prog       <= prog_nx;
      req_chip_erase <= chip_nx;
      req_sect_start <= start_nx;
      req_suspend    <= susp_nx;
      req_resume     <= res_nx;
      if (prog_nx) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

  assign read_mode       = (state == S_READ);
  assign autosel_mode    = (state == S_AUTO);
  assign erase_suspended = (state == S_SUSP);

  p_prog_enters_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_prog |-> (state == S_PROG_RUN));
  p_start_has_sector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_sect_start |-> (sect_mask != '0));
  p_suspend_from_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_suspend |-> ($past(state) == S_SE_RUN));
  p_resume_from_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_resume |-> ($past(state) == S_SUSP));
  p_single_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_prog, req_chip_erase, req_sect_start, req_suspend, req_resume}));
  p_susp_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_suspended && !wr_en) |=> erase_suspended);
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  localparam int AW = 16, DW = 16, NS = 8, WIN = 6;

  logic clk = 0, rst_n = 0, byte_mode = 0, wr_en = 0, eng_busy = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic read_mode, autosel_mode, erase_suspended, req_prog, req_chip_erase;
  logic req_sect_start, req_suspend, req_resume;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic [NS-1:0] sect_mask;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .N_SECT(NS), .WIN_CYC(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .eng_busy(eng_busy),
    .read_mode(read_mode), .autosel_mode(autosel_mode),
    .erase_suspended(erase_suspended), .req_prog(req_prog),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .req_chip_erase(req_chip_erase), .req_sect_start(req_sect_start),
    .sect_mask(sect_mask), .req_suspend(req_suspend), .req_resume(req_resume));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic unlock();
    if (byte_mode) begin wr(16'hAAAA, 16'h00AA); wr(16'h5554, 16'h0055); end
    else begin wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); end
  endtask

  function automatic logic [AW-1:0] cmd_a();
    return byte_mode ? 16'hAAAA : 16'h5555;
  endfunction

  // engine runs a few clocks then finishes; decoder returns to read one clock after the fall
  task automatic engine_run(input string tag);
    eng_busy = 1; repeat (3) @(negedge clk);
    check({tag, " busy holds run"}, read_mode, 0);
    eng_busy = 0; @(negedge clk);
    check({tag, " back to read"}, read_mode, 1);
  endtask

  task automatic t_reset();
    check("R1 read_mode", read_mode, 1);
    check("R1 autosel", autosel_mode, 0);
    check("R1 suspended", erase_suspended, 0);
    check("R1 mask", sect_mask, 0);
    check("R1 pulses", {req_prog, req_chip_erase, req_sect_start, req_suspend, req_resume}, 0);
  endtask

  task automatic t_program();
    unlock(); wr(16'h5555, 16'h00A0); wr(16'h0ABC, 16'hBEEF);
    check("R2 req_prog", req_prog, 1);
    check("R2 prog_addr", prog_addr, 16'h0ABC);
    check("R2 prog_data", prog_data, 16'hBEEF);
    @(negedge clk);
    check("R2 pulse one clock", req_prog, 0);
    eng_busy = 1;
    wr(16'h5555, 16'h00AA); wr(16'h0000, 16'h00B0);
    check("R11 no request in run", {req_prog, req_chip_erase, req_suspend}, 0);
    check("R11 still running", read_mode, 0);
    eng_busy = 0; @(negedge clk);
    check("R9 program done read", read_mode, 1);
  endtask

  task automatic t_byte_mode();
    byte_mode = 1;
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0); wr(16'h0100, 16'h0011);
    check("R3 word addr no unlock", req_prog, 0);
    unlock(); wr(16'hAAAA, 16'h00A0); wr(16'h0102, 16'h0033);
    check("R3 byte program", req_prog, 1);
    check("R3 byte addr", prog_addr, 16'h0102);
    engine_run("R9 byte prog");
    byte_mode = 0;
  endtask

  task automatic t_upper_ignored();
    wr(16'h5555, 16'hC3AA); wr(16'h2AAA, 16'h7E55); wr(16'h5555, 16'hFFA0); wr(16'h0200, 16'h1234);
    check("R7 upper bits ignored", req_prog, 1);
    engine_run("R7 run");
  endtask

  task automatic t_mismatch();
    wr(16'h5555, 16'h00AA); wr(16'h2AAB, 16'h0055);
    check("R6 bad addr read", read_mode, 1);
    wr(16'h5555, 16'h00A0); wr(16'h0300, 16'h0001);
    check("R6 no program after abort", req_prog, 0);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0054);
    check("R6 bad data read", read_mode, 1);
  endtask

  task automatic t_chip_erase();
    unlock(); wr(16'h5555, 16'h0080); unlock(); wr(16'h5555, 16'h0010);
    check("R4 chip erase", req_chip_erase, 1);
    eng_busy = 1;
    wr(16'h0000, 16'h00B0);
    check("R8 no suspend in chip erase", req_suspend, 0);
    check("R8 not suspended", erase_suspended, 0);
    eng_busy = 0; @(negedge clk);
    check("R9 chip done read", read_mode, 1);
  endtask

  task automatic t_sector();
    unlock(); wr(16'h5555, 16'h0080); unlock();
    wr(16'h4000, 16'h0030); wr(16'hE123, 16'h0030);
    repeat (WIN - 1) @(negedge clk);
    check("R5 no start early", req_sect_start, 0);
    @(negedge clk);
    check("R5 start on time", req_sect_start, 1);
    check("R5 mask", sect_mask, 8'h84);
    eng_busy = 1; @(negedge clk);
    wr(16'h0000, 16'h00B0);
    check("R8 suspend pulse", req_suspend, 1);
    check("R8 suspended", erase_suspended, 1);
    eng_busy = 0; repeat (2) @(negedge clk);
    check("R9 stays suspended", erase_suspended, 1);
    wr(16'h0000, 16'h0030);
    check("R8 resume pulse", req_resume, 1);
    check("R8 resumed", erase_suspended, 0);
    engine_run("R9 sector");
  endtask

  task automatic t_sector_abort();
    unlock(); wr(16'h5555, 16'h0080); unlock();
    wr(16'h2000, 16'h0030); wr(16'h2000, 16'h0010);
    check("R6 window abort read", read_mode, 1);
    repeat (WIN + 1) begin
      @(negedge clk);
      check("R6 no start after abort", req_sect_start, 0);
    end
  endtask

  task automatic t_autosel();
    wr(16'h0000, 16'h00B0);
    check("R8 no suspend in read", req_suspend, 0);
    unlock(); wr(16'h5555, 16'h0090);
    check("R10 autosel on", autosel_mode, 1);
    wr(16'h0000, 16'h00F0);
    check("R10 autosel off", autosel_mode, 0);
    check("R10 read mode", read_mode, 1);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_byte_mode();
    t_upper_ignored();
    t_mismatch();
    t_chip_erase();
    t_sector();
    t_sector_abort();
    t_autosel();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule